// File: doc/BRIEF.md
# ISA Bus Slave Register Interface

This block is the host-facing front end of a peripheral that sits on a legacy 16-bit ISA-style bus. It watches the host strobes through a local system clock, decodes I/O cycles against a parameterised base address, and gives the host a bank of eight 16-bit read/write registers. The data bus is split into an input, an output and a drive enable, so a pad ring can build the bidirectional pin from them. A second address window in memory space maps onto the same registers. When that window is hit and memory mode is enabled, an open-drain 16-bit chip-select indication is raised.

Accesses are gated by the bus environment. A high address-enable means a DMA cycle, and it blocks I/O slave cycles. A low refresh line means a DRAM refresh, and it silences every host strobe. The raw reset pin is accepted only after it has stayed high long enough. The required number of samples is derived from the clock frequency and a minimum time of 400 ns.

Top module: `isa_slave_regs`

## Requirements
- R1: After `rst_pin` has been sampled high on at least RST_CYC consecutive clocks (40 at the default 100 MHz), every register reads back as 0x0000. The memory-enable bit is cleared, so `memcs16_oe` stays low even inside the memory window.
- R2: A high pulse on `rst_pin` shorter than RST_CYC samples resets nothing. Any single low sample restarts the count, so two short pulses separated by one low cycle also reset nothing.
- R3: An I/O write to IO_BASE + 2*k (k = 0..7, selected by address bits 3..1) stores `sd_in` into register k. A later I/O read at the same address returns it on `sd_out` with `sd_oe` high.
- R4: The I/O decode compares address bits 15..4 only. Bits 19..16 are ignored, and an address outside the 16-byte window neither drives `sd_oe` nor writes a register.
- R5: `sd_oe` is high only while a decoded read strobe (I/O or memory) is active, and is low at all other times.
- R6: While `aen` is high, I/O reads do not drive the bus and I/O writes change no register. Memory-space accesses are not affected by `aen`.
- R7: While `refresh_n` is low, `ior_n`, `iow_n`, `memr_n` and `memw_n` are all ignored: no drive, no write.
- R8: A write commits exactly once, when the synchronised write strobe becomes active. Changing `sd_in` later in the same strobe has no effect.
- R9: `memcs16_oe` is high only when address bits 19..12 match the memory window base and bit 10 of register 7 (memory enable) is set.
- R10: With memory enable set, memory reads and writes inside the window access register k through address bits 3..1. With memory enable clear, memory strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_pin | input | 1 | Raw active-high asynchronous reset pin |
| sa | input | 20 | Host address bus |
| sd_in | input | 16 | Data bus value seen at the pin |
| sd_out | output | 16 | Data bus value to drive |
| sd_oe | output | 1 | Data bus drive enable |
| aen | input | 1 | Active-high DMA address enable |
| refresh_n | input | 1 | Active-low DRAM refresh |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| memr_n | input | 1 | Active-low memory read strobe |
| memw_n | input | 1 | Active-low memory write strobe |
| memcs16_oe | output | 1 | Pull-down enable of the open-drain 16-bit memory chip-select |

## Verification
The hardest case to reach from the ports is a reset pin that stays high for a long time without the block resetting. The stimulus writes known values first, then applies a 30-cycle pulse and a pair of 30-cycle pulses split by a single low cycle. It then reads every register back. A second hard case is a write strobe held low while the data changes after the commit cycle. The bench first waits for the synchroniser latency to pass, then swaps the data and checks that the first value stuck.

// File: rtl/isa_slave_pkg.sv
package isa_slave_pkg;
   localparam int WORD_W = 16;
   typedef logic [WORD_W-1:0] word_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int cycles_for_ns(input longint clk_hz, input longint ns);
      return int'((clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction
endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) chain[0] <= d;

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/isa_rst_qual.sv
module isa_rst_qual #(
   parameter int MIN_CYC = 40
) (
   input  logic clk,
   input  logic pin_s,
   output logic rst_q
);
   generate
      if (MIN_CYC <= 1) begin : g_direct
         always_ff @(posedge clk) rst_q <= pin_s;
      end else begin : g_count
         localparam int CW = $clog2(MIN_CYC + 1);
         localparam logic [CW-1:0] TOP = CW'(MIN_CYC);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!pin_s)          cnt <= '0;
            else if (cnt != TOP) cnt <= cnt + 1'b1;
         end
         assign rst_q = (cnt == TOP);
      end
   endgenerate
endmodule

// File: rtl/isa_regbank.sv
module isa_regbank
   import isa_slave_pkg::*;
#(
   parameter int NREG = 8,
   parameter int SELW = 3
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we,
   input  logic [SELW-1:0]        wsel,
   input  word_t                  wdata,
   output logic [NREG-1:0][WORD_W-1:0] q
);
   generate
      for (genvar k = 0; k < NREG; k++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)                            q[k] <= '0;
            else if (we && wsel == SELW'(k))    q[k] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/isa_slave_regs.sv
module isa_slave_regs
   import isa_slave_pkg::*;
#(
   parameter logic [15:0] IO_BASE     = 16'h0300,
   parameter int          IO_WIN      = 16,
   parameter logic [19:0] MEM_BASE    = 20'hD0000,
   parameter int          MEM_WIN     = 4096,
   parameter int          CTRL_IDX    = 7,
   parameter int          MEM_EN_BIT  = 10,
   parameter longint      CLK_HZ      = 100_000_000,
   parameter int          RST_MIN_NS  = 400,
   parameter int          SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_pin,
   input  logic [19:0] sa,
   input  logic [15:0] sd_in,
   output logic [15:0] sd_out,
   output logic        sd_oe,
   input  logic        aen,
   input  logic        refresh_n,
   input  logic        ior_n,
   input  logic        iow_n,
   input  logic        memr_n,
   input  logic        memw_n,
   output logic        memcs16_oe
);
   localparam int IO_LSB  = $clog2(IO_WIN);
   localparam int MEM_LSB = $clog2(MEM_WIN);
   localparam int NREG    = IO_WIN / 2;
   localparam int SELW    = IO_LSB - 1;
   localparam int RST_CYC = cycles_for_ns(CLK_HZ, RST_MIN_NS);

   generate
      if (!is_pow2(IO_WIN) || IO_WIN < 4 || IO_WIN > 65536) begin : g_bad_io
         $error("IO_WIN must be a power of two from 4 to 65536");
      end
      if (!is_pow2(MEM_WIN) || MEM_WIN < IO_WIN || MEM_WIN > 1048576) begin : g_bad_mem
         $error("MEM_WIN must be a power of two, at least IO_WIN");
      end
      if (CTRL_IDX >= NREG || MEM_EN_BIT >= WORD_W) begin : g_bad_ctrl
         $error("control bit location outside the register bank");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // synchronised strobes
   logic pin_s;
   logic aen_s, refresh_n_s, ior_n_s, iow_n_s, memr_n_s, memw_n_s;

   isa_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .d(rst_pin), .q(pin_s));

   isa_sync #(.W(6), .STAGES(SYNC_STAGES)) u_bus_sync (
      .clk(clk),
      .d({aen, refresh_n, ior_n, iow_n, memr_n, memw_n}),
      .q({aen_s, refresh_n_s, ior_n_s, iow_n_s, memr_n_s, memw_n_s}));

   logic rst_q;
   isa_rst_qual #(.MIN_CYC(RST_CYC)) u_rst (
      .clk(clk), .pin_s(pin_s), .rst_q(rst_q));

   // address decode
   logic io_hit, mem_hit, mem_en;
   logic [SELW-1:0] sel;
   logic unused_bits;

   assign io_hit  = (sa[15:IO_LSB] == IO_BASE[15:IO_LSB]);
   assign mem_hit = (sa[19:MEM_LSB] == MEM_BASE[19:MEM_LSB]);
   assign sel     = sa[IO_LSB-1:1];
   assign unused_bits = sa[0];

   // strobe edge detection
   logic iow_prev, memw_prev;
   always_ff @(posedge clk) begin
      if (rst_q) begin
         iow_prev  <= 1'b1;
         memw_prev <= 1'b1;
      end else begin
         iow_prev  <= iow_n_s;
         memw_prev <= memw_n_s;
      end
   end

   logic io_ok, mem_ok, io_commit, mem_commit, we;
   assign io_ok      = refresh_n_s && !aen_s && io_hit && !rst_q;
   assign mem_ok     = refresh_n_s && mem_hit && mem_en && !rst_q;
   assign io_commit  = io_ok  && !iow_n_s  && iow_prev;
   assign mem_commit = mem_ok && !memw_n_s && memw_prev;
   assign we         = io_commit || mem_commit;

   logic [NREG-1:0][WORD_W-1:0] regs_q;
   isa_regbank #(.NREG(NREG), .SELW(SELW)) u_bank (
      .clk(clk), .rst(rst_q), .we(we), .wsel(sel), .wdata(sd_in), .q(regs_q));

   assign mem_en = regs_q[CTRL_IDX][MEM_EN_BIT];

   // read path
   logic rd_act;
   assign rd_act     = (io_ok && !ior_n_s) || (mem_ok && !memr_n_s);
   assign sd_oe      = rd_act;
   assign sd_out     = rd_act ? regs_q[sel] : '0;
   assign memcs16_oe = mem_hit && mem_en && !rst_q;
endmodule

// File: rtl/isa_slave_regs_chk.sv
module isa_slave_regs_chk (
   input logic clk,
   input logic rst_q,
   input logic pin_s,
   input logic aen_s,
   input logic refresh_n_s,
   input logic ior_n_s,
   input logic memr_n_s,
   input logic mem_en,
   input logic sd_oe,
   input logic memcs16_oe
);
   AST_RESET_NEEDS_PIN: assert property (@(posedge clk) disable iff ($isunknown(rst_q))
      (rst_q === 1'b1) |-> $past(pin_s)); // R2
   AST_RESET_CLEARS_EN: assert property (@(posedge clk) disable iff ($isunknown(rst_q))
      (rst_q === 1'b0 && $past(rst_q) === 1'b1) |-> !mem_en); // R1
   AST_DRIVE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst_q !== 1'b0)
      sd_oe |-> (!ior_n_s || !memr_n_s)); // R5
   AST_AEN_BLOCKS_IO: assert property (@(posedge clk) disable iff (rst_q !== 1'b0)
      (sd_oe && aen_s) |-> !memr_n_s); // R6
   AST_REFRESH_NO_DRIVE: assert property (@(posedge clk) disable iff (rst_q !== 1'b0)
      !refresh_n_s |-> !sd_oe); // R7
   AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (rst_q !== 1'b0)
      !refresh_n_s |=> $stable(mem_en)); // R7
   AST_MEMCS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst_q !== 1'b0)
      memcs16_oe |-> mem_en); // R9
endmodule

bind isa_slave_regs isa_slave_regs_chk u_chk (
   .clk(clk), .rst_q(rst_q), .pin_s(pin_s), .aen_s(aen_s),
   .refresh_n_s(refresh_n_s), .ior_n_s(ior_n_s), .memr_n_s(memr_n_s),
   .mem_en(mem_en), .sd_oe(sd_oe), .memcs16_oe(memcs16_oe));

// File: tb/tb_isa_slave_regs.sv
module tb_isa_slave_regs;
   logic        clk = 1'b0;
   logic        rst_pin = 1'b0;
   logic [19:0] sa = '0;
   logic [15:0] sd_in = '0;
   logic [15:0] sd_out;
   logic        sd_oe;
   logic        aen = 1'b0, refresh_n = 1'b1;
   logic        ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
   logic        memcs16_oe;

   localparam logic [19:0] IOB  = 20'h00300;
   localparam logic [19:0] MEMB = 20'hD0000;
   localparam logic [15:0] EN_BIT = 16'h0400;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   isa_slave_regs dut (
      .clk(clk), .rst_pin(rst_pin), .sa(sa), .sd_in(sd_in), .sd_out(sd_out),
      .sd_oe(sd_oe), .aen(aen), .refresh_n(refresh_n), .ior_n(ior_n),
      .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n), .memcs16_oe(memcs16_oe));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_rst(input int n);
      @(negedge clk) rst_pin = 1'b1;
      repeat (n) @(negedge clk);
      rst_pin = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic bus_write(input logic [19:0] a, input logic [15:0] d, input bit mem);
      @(negedge clk);
      sa = a; sd_in = d;
      if (mem) memw_n = 1'b0; else iow_n = 1'b0;
      repeat (4) @(negedge clk);
      memw_n = 1'b1; iow_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_read(input logic [19:0] a, input bit mem, output logic [15:0] d, output logic oe);
      @(negedge clk);
      sa = a;
      if (mem) memr_n = 1'b0; else ior_n = 1'b0;
      repeat (3) @(negedge clk);
      d = sd_out; oe = sd_oe;
      memr_n = 1'b1; ior_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [15:0] pat(input int k, input int salt);
      return 16'(16'hA5C3 ^ (k * 16'h1111) ^ (salt * 16'h0F0F));
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] d;
      logic oe;
      repeat (4) @(negedge clk);
      pulse_rst(50);

      // R1 reset state
      for (int k = 0; k < 8; k++) begin
         bus_read(IOB + 20'(2*k), 1'b0, d, oe);
         chk(oe && d == 16'h0, "R1 reset value", {15'd0, oe, d}, {16'd1, 16'h0});
      end
      @(negedge clk) sa = MEMB;
      @(negedge clk) chk(!memcs16_oe, "R1 memcs inactive after reset", memcs16_oe, 0);

      // R3 sweep all registers, R5 idle bus
      for (int k = 0; k < 8; k++) bus_write(IOB + 20'(2*k), pat(k, 0) & ~EN_BIT, 1'b0);
      for (int k = 0; k < 8; k++) begin
         bus_read(IOB + 20'(2*k), 1'b0, d, oe);
         chk(oe && d == (pat(k, 0) & ~EN_BIT), "R3 write/read", d, pat(k, 0) & ~EN_BIT);
      end
      @(negedge clk) sa = IOB;
      @(negedge clk) chk(!sd_oe, "R5 no drive without strobe", sd_oe, 0);

      // R2 short pulse and split pulse
      pulse_rst(30);
      bus_read(IOB + 20'd2, 1'b0, d, oe);
      chk(d == (pat(1, 0) & ~EN_BIT), "R2 short pulse ignored", d, pat(1, 0) & ~EN_BIT);
      @(negedge clk) rst_pin = 1'b1;
      repeat (30) @(negedge clk);
      rst_pin = 1'b0;
      @(negedge clk) rst_pin = 1'b1;
      repeat (30) @(negedge clk);
      rst_pin = 1'b0;
      repeat (6) @(negedge clk);
      bus_read(IOB + 20'd4, 1'b0, d, oe);
      chk(d == (pat(2, 0) & ~EN_BIT), "R2 split pulse ignored", d, pat(2, 0) & ~EN_BIT);

      // R4 upper bits ignored, outside window
      bus_write({4'hA, 16'h0306}, 16'h1357, 1'b0);
      bus_read(20'h00306, 1'b0, d, oe);
      chk(d == 16'h1357, "R4 bits 19..16 ignored", d, 16'h1357);
      bus_read(IOB + 20'h10, 1'b0, d, oe);
      chk(!oe, "R4 outside window no drive", oe, 0);
      bus_write(20'h00316, 16'hDEAD, 1'b0);
      bus_read(20'h00306, 1'b0, d, oe);
      chk(d == 16'h1357, "R4 outside window no write", d, 16'h1357);

      // R6 aen blocks I/O
      aen = 1'b1;
      bus_read(IOB, 1'b0, d, oe);
      chk(!oe, "R6 aen blocks read", oe, 0);
      bus_write(IOB, 16'hBEEF, 1'b0);
      aen = 1'b0;
      repeat (3) @(negedge clk);
      bus_read(IOB, 1'b0, d, oe);
      chk(d == (pat(0, 0) & ~EN_BIT), "R6 aen blocks write", d, pat(0, 0) & ~EN_BIT);

      // R8 single commit
      @(negedge clk);
      sa = 20'h00308; sd_in = 16'h2468; iow_n = 1'b0;
      repeat (5) @(negedge clk);
      sd_in = 16'hFFFF;
      repeat (3) @(negedge clk);
      iow_n = 1'b1;
      repeat (3) @(negedge clk);
      bus_read(20'h00308, 1'b0, d, oe);
      chk(d == 16'h2468, "R8 commit once", d, 16'h2468);

      // R10 memory strobes ignored while disabled
      bus_read(MEMB, 1'b1, d, oe);
      chk(!oe, "R10 mem read ignored when disabled", oe, 0);

      // R9 enable memory mode (reg 7 bit 10)
      bus_write(IOB + 20'hE, EN_BIT | 16'h0011, 1'b0);
      for (int i = 0; i < 4; i++) begin
         logic [19:0] a;
         bit exp;
         a = (i == 0) ? MEMB + 20'h0FFE : (i == 1) ? MEMB + 20'h1000 :
             (i == 2) ? 20'h50000 : MEMB;
         exp = (i == 0 || i == 3);
         @(negedge clk) sa = a;
         @(negedge clk) chk(memcs16_oe == exp, "R9 memcs window decode", memcs16_oe, exp);
      end

      // R10 memory access with aen high
      aen = 1'b1;
      bus_write(MEMB + 20'h4, 16'h7777, 1'b1);
      bus_read(MEMB + 20'h4, 1'b1, d, oe);
      chk(oe && d == 16'h7777, "R10 memory access", d, 16'h7777);
      aen = 1'b0;
      bus_read(IOB + 20'h4, 1'b0, d, oe);
      chk(d == 16'h7777, "R10 memory write lands in bank", d, 16'h7777);

      // R7 refresh silences everything
      refresh_n = 1'b0;
      repeat (3) @(negedge clk);
      bus_read(IOB + 20'h4, 1'b0, d, oe);
      chk(!oe, "R7 refresh blocks io read", oe, 0);
      bus_read(MEMB + 20'h4, 1'b1, d, oe);
      chk(!oe, "R7 refresh blocks mem read", oe, 0);
      bus_write(IOB + 20'h4, 16'h0BAD, 1'b0);
      bus_write(MEMB + 20'hE, 16'h0000, 1'b1);
      refresh_n = 1'b1;
      repeat (3) @(negedge clk);
      bus_read(IOB + 20'h4, 1'b0, d, oe);
      chk(d == 16'h7777, "R7 refresh blocks io write", d, 16'h7777);
      bus_read(IOB + 20'hE, 1'b0, d, oe);
      chk(d == (EN_BIT | 16'h0011), "R7 refresh blocks mem write", d, EN_BIT | 16'h0011);

      // R1 full reset clears all again
      pulse_rst(45);
      for (int k = 0; k < 8; k++) begin
         bus_read(IOB + 20'(2*k), 1'b0, d, oe);
         chk(d == 16'h0, "R1 reset clears bank", d, 0);
      end
      @(negedge clk) sa = MEMB;
      @(negedge clk) chk(!memcs16_oe, "R1 memory enable cleared", memcs16_oe, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule